// File: doc/BRIEF.md
# Configurable Gated Event Counter

This block counts events on an asynchronous input and drives one digital output. A 16-bit configuration word decides how the counter and the output behave. It selects:

- whether the preset load follows the level or the rising edge of its command;
- the gate polarity that inhibits counting;
- which host commands are honoured;
- pulse mode, with a programmable pulse length;
- whether the output clears on a counter reset or at the end of a pulse;
- whether a host-activity watchdog may clear the output.

The configuration is held in two places. The stored word models non-volatile storage and accepts host writes only while the unlock input is high. The active word drives behaviour, and it copies the stored word only during a power-on reset (`rst_n` low). A factory-restore input (`factory_n` low) loads the default word 0x0108 into both copies. The host reads both words: the stored word shows what the next power cycle will apply, and the active word shows what is in force now.

Counting uses a two-flop synchroniser and a rising-edge detector on the count input. The counter adds one per accepted edge and wraps at its width.

Top module: `gated_event_counter`

## Requirements
- R1: While `wr_unlock` is low, a write strobe on `cfg_wr_en` leaves `cfg_pending` unchanged. With `wr_unlock` high, the written word appears on `cfg_pending` one cycle later.
- R2: `cfg_active` changes only while `rst_n` is low, when it takes the `cfg_pending` value. `factory_n` low loads 0x0108 into both words. Behaviour always follows `cfg_active`, never the pending word.
- R3: Each rising edge on `cnt_in` adds one to `count`, unless the gate blocks it. With active bit 8 = 0, counting is blocked while `gate` is low. With bit 8 = 1, counting is blocked while `gate` is high.
- R4: With active bit 3 = 0, `count` is forced to `preset_val` on every cycle that `ctrl_set` is high, and edges are not counted meanwhile. With bit 3 = 1, the preset is loaded once per rising edge of `ctrl_set`, and counting continues while it stays high.
- R5: Active bit 4 enables `ctrl_out_set`, bit 5 enables `ctrl_out_rst`, and bit 6 enables `ctrl_cnt_rst`. A command whose bit is 0 has no effect on `dout` or `count`.
- R6: With active bit 10 = 0, an enabled counter reset clears both `count` and `dout`.
- R7: With active bits 7 and 10 both set, a set command raises `dout` for exactly `pulse_len` cycles (a length of 0 acts as 1). In this configuration a counter reset does not clear `dout`.
- R8: With active bit 2 = 0, if `WDOG_CYCLES` cycles pass without a `host_kick` pulse, `dout` is cleared and held low. With bit 2 = 1 the watchdog never acts.
- R9: Bits 0, 1, 9 and 11 to 15 of the active word have no effect, but they are stored and read back.
- R10: After power-on reset, `count` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; copies the stored word into the active word |
| factory_n | input | 1 | Synchronous active-low restore of the default configuration |
| wr_unlock | input | 1 | Write protection lifted while high |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 16 | Configuration word to store |
| cfg_pending | output | 16 | Stored word that the next power-on reset applies |
| cfg_active | output | 16 | Word currently in force |
| ctrl_set | input | 1 | Preset load command |
| ctrl_cnt_rst | input | 1 | Counter reset command |
| ctrl_out_set | input | 1 | Output set command |
| ctrl_out_rst | input | 1 | Output reset command |
| host_kick | input | 1 | Host activity pulse that restarts the watchdog |
| preset_val | input | COUNT_W | Value loaded by the preset command |
| pulse_len | input | PULSE_W | Pulse length in cycles |
| gate | input | 1 | Gate input, synchronous to clk |
| cnt_in | input | 1 | Asynchronous event input |
| count | output | COUNT_W | Event count |
| dout | output | 1 | Digital output |

## Verification
The hardest situation to reach is the gap between the stored and the active configuration. A write must visibly change `cfg_pending` while commands keep obeying the old word, until `rst_n` is pulsed. The stimulus writes a word that enables the set command, issues the command, and shows `dout` stay low. It then pulses `rst_n` alone and repeats the command. The watchdog is reached with a shortened `WDOG_CYCLES`, kicked at intervals below the limit and then left alone.

// File: rtl/gec_pkg.sv
// Package: shared configuration constants and the decoded mode record.
// Assumes a 16-bit configuration word; undefined bit positions are ignored.
package gec_pkg;
    localparam int CFG_W = 16;
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 16'h0108;

    localparam int B_WDOG_OFF  = 2;
    localparam int B_SET_EDGE  = 3;
    localparam int B_OSET_EN   = 4;
    localparam int B_ORST_EN   = 5;
    localparam int B_CRST_EN   = 6;
    localparam int B_PULSE_EN  = 7;
    localparam int B_INH_HIGH  = 8;
    localparam int B_CLR_PULSE = 10;

    typedef struct packed {
        logic wdog_off;
        logic set_on_edge;
        logic out_set_en;
        logic out_rst_en;
        logic cnt_rst_en;
        logic pulse_en;
        logic inhibit_high;
        logic clr_on_pulse;
    } gec_mode_t;

    function automatic gec_mode_t decode_mode(input logic [CFG_W-1:0] w);
        gec_mode_t m;
        m.wdog_off     = w[B_WDOG_OFF];
        m.set_on_edge  = w[B_SET_EDGE];
        m.out_set_en   = w[B_OSET_EN];
        m.out_rst_en   = w[B_ORST_EN];
        m.cnt_rst_en   = w[B_CRST_EN];
        m.pulse_en     = w[B_PULSE_EN];
        m.inhibit_high = w[B_INH_HIGH];
        m.clr_on_pulse = w[B_CLR_PULSE];
        return m;
    endfunction
endpackage

// File: rtl/gec_cfg_store.sv
// Module: stored (pending) and active configuration words.
// The stored word models non-volatile storage: only factory_n resets it.
// The active word copies the stored word while rst_n is low.
module gec_cfg_store
    import gec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             factory_n,
    input  logic             wr_unlock,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] pend_o,
    output logic [CFG_W-1:0] active_o
);
    logic [CFG_W-1:0] pend_q;
    logic [CFG_W-1:0] active_q;

    // Stored word: accepts a write only while protection is lifted.
    always_ff @(posedge clk) begin
        if (!factory_n)
            pend_q <= CFG_DEFAULT;
        else if (wr_en && wr_unlock)
            pend_q <= wr_data;
    end

    // Active word: takes the stored word during power-on reset only.
    always_ff @(posedge clk) begin
        if (!factory_n)
            active_q <= CFG_DEFAULT;
        else if (!rst_n)
            active_q <= pend_q;
    end

    assign pend_o   = pend_q;
    assign active_o = active_q;

    assert_locked_hold_R1: assert property (@(posedge clk) disable iff (!factory_n)
        !(wr_en && wr_unlock) |=> $stable(pend_q));

    assert_active_frozen_R2: assert property (@(posedge clk) disable iff (!factory_n)
        rst_n |=> $stable(active_q));
endmodule

// File: rtl/gec_edge_sync.sv
// Module: synchroniser chain with rising-edge detection.
// Assumes async_i stays stable for longer than STAGES+1 clock cycles per level.
module gec_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    // Shift the raw input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/gec_counter.sv
// Module: event counter with gate, preset load and counter reset.
// Priority: counter reset, then preset load, then count. The gate is synchronous.
module gec_counter #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_on_edge,
    input  logic               inhibit_high,
    input  logic               cnt_rst_en,
    input  logic               gate,
    input  logic               cnt_rise,
    input  logic               set_cmd,
    input  logic               rst_cmd,
    input  logic [COUNT_W-1:0] preset,
    output logic [COUNT_W-1:0] count_o,
    output logic               cleared_o
);
    logic [COUNT_W-1:0] count_q;
    logic               set_q;
    logic               load;
    logic               gate_open;
    logic               do_rst;

    assign load      = set_on_edge ? (set_cmd & ~set_q) : set_cmd;
    assign gate_open = inhibit_high ? ~gate : gate;
    assign do_rst    = rst_cmd & cnt_rst_en;

    // Counter state and preset-command history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            set_q   <= 1'b0;
        end else begin
            set_q <= set_cmd;
            if (do_rst)
                count_q <= '0;
            else if (load)
                count_q <= preset;
            else if (cnt_rise && gate_open)
                count_q <= count_q + 1'b1;
        end
    end

    assign count_o   = count_q;
    assign cleared_o = do_rst;

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rise && gate_open && !do_rst && !load) |=> count_q == $past(count_q) + 1'b1);

    assert_gate_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !do_rst && !load) |=> $stable(count_q));

    assert_preset_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !do_rst) |=> count_q == $past(preset));

    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> count_q == '0);
endmodule

// File: rtl/gec_watchdog.sv
// Module: host-activity watchdog; expires after LIMIT cycles without a kick.
// Assumes LIMIT >= 1. The timer saturates until the next kick.
module gec_watchdog #(
    parameter int LIMIT = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic kick,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] tmr_q;

    // Count idle cycles since the last kick, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || kick)
            tmr_q <= '0;
        else if (tmr_q != LIM)
            tmr_q <= tmr_q + 1'b1;
    end

    assign expired_o = enable && (tmr_q == LIM);

    assert_kick_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !expired_o);
endmodule

// File: rtl/gec_output_ctl.sv
// Module: digital output with set/reset commands, pulse timer and clear policy.
// Priority: clear sources, then set, then pulse expiry, then timer step.
module gec_output_ctl #(
    parameter int PULSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               out_set_en,
    input  logic               out_rst_en,
    input  logic               pulse_en,
    input  logic               clr_on_pulse,
    input  logic               set_cmd,
    input  logic               rst_cmd,
    input  logic               cnt_cleared,
    input  logic               wd_expired,
    input  logic [PULSE_W-1:0] pulse_len,
    output logic               dout_o
);
    logic               dout_q;
    logic [PULSE_W-1:0] timer_q;
    logic               set_ok;
    logic               clear_now;
    logic               timed;
    logic               pulse_done;

    assign set_ok     = set_cmd & out_set_en;
    assign timed      = pulse_en & clr_on_pulse;
    assign clear_now  = wd_expired | (rst_cmd & out_rst_en) | (~clr_on_pulse & cnt_cleared);
    assign pulse_done = timed & dout_q & (timer_q <= PULSE_W'(1));

    // Output level and remaining pulse time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= 1'b0;
            timer_q <= '0;
        end else if (clear_now) begin
            dout_q  <= 1'b0;
            timer_q <= '0;
        end else if (set_ok) begin
            dout_q  <= 1'b1;
            timer_q <= pulse_len;
        end else if (pulse_done) begin
            dout_q  <= 1'b0;
            timer_q <= '0;
        end else if (timed && dout_q) begin
            timer_q <= timer_q - 1'b1;
        end
    end

    assign dout_o = dout_q;

    assert_wdog_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expired |=> !dout_q);

    assert_pulse_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (timed && dout_q && timer_q > PULSE_W'(1) && !clear_now && !set_ok)
        |=> (dout_q && timer_q == $past(timer_q) - 1'b1));

    assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cleared && !clr_on_pulse) |=> !dout_q);

    assert_reset_state_dout_R10: assert property (@(posedge clk)
        !rst_n |=> !dout_q);
endmodule

// File: rtl/gated_event_counter.sv
// Module: top of the configurable gated event counter.
// Behaviour is decoded from the active configuration word only.
module gated_event_counter
    import gec_pkg::*;
#(
    parameter int COUNT_W     = 16,
    parameter int PULSE_W     = 16,
    parameter int WDOG_CYCLES = 5_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               factory_n,
    input  logic               wr_unlock,
    input  logic               cfg_wr_en,
    input  logic [15:0]        cfg_wr_data,
    output logic [15:0]        cfg_pending,
    output logic [15:0]        cfg_active,
    input  logic               ctrl_set,
    input  logic               ctrl_cnt_rst,
    input  logic               ctrl_out_set,
    input  logic               ctrl_out_rst,
    input  logic               host_kick,
    input  logic [COUNT_W-1:0] preset_val,
    input  logic [PULSE_W-1:0] pulse_len,
    input  logic               gate,
    input  logic               cnt_in,
    output logic [COUNT_W-1:0] count,
    output logic               dout
);
    gec_mode_t mode;
    logic      cnt_rise;
    logic      cleared;
    logic      wd_expired;

    assign mode = decode_mode(cfg_active);

    gec_cfg_store u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .factory_n(factory_n),
        .wr_unlock(wr_unlock),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .pend_o   (cfg_pending),
        .active_o (cfg_active)
    );

    gec_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cnt_in),
        .rise_o (cnt_rise)
    );

    gec_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_on_edge (mode.set_on_edge),
        .inhibit_high(mode.inhibit_high),
        .cnt_rst_en  (mode.cnt_rst_en),
        .gate        (gate),
        .cnt_rise    (cnt_rise),
        .set_cmd     (ctrl_set),
        .rst_cmd     (ctrl_cnt_rst),
        .preset      (preset_val),
        .count_o     (count),
        .cleared_o   (cleared)
    );

    gec_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (~mode.wdog_off),
        .kick     (host_kick),
        .expired_o(wd_expired)
    );

    gec_output_ctl #(.PULSE_W(PULSE_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .out_set_en  (mode.out_set_en),
        .out_rst_en  (mode.out_rst_en),
        .pulse_en    (mode.pulse_en),
        .clr_on_pulse(mode.clr_on_pulse),
        .set_cmd     (ctrl_out_set),
        .rst_cmd     (ctrl_out_rst),
        .cnt_cleared (cleared),
        .wd_expired  (wd_expired),
        .pulse_len   (pulse_len),
        .dout_o      (dout)
    );
endmodule

// File: tb/gated_event_counter_bench.sv
module gated_event_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        factory_n = 1'b0;
    logic        wr_unlock = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic [15:0] cfg_pending;
    logic [15:0] cfg_active;
    logic        ctrl_set = 1'b0;
    logic        ctrl_cnt_rst = 1'b0;
    logic        ctrl_out_set = 1'b0;
    logic        ctrl_out_rst = 1'b0;
    logic        host_kick = 1'b0;
    logic [15:0] preset_val = '0;
    logic [15:0] pulse_len = '0;
    logic        gate = 1'b0;
    logic        cnt_in = 1'b0;
    logic [15:0] count;
    logic        dout;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_event_counter #(.WDOG_CYCLES(WDOG)) u_gated_event_counter (
        .clk(clk), .rst_n(rst_n), .factory_n(factory_n), .wr_unlock(wr_unlock),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_pending(cfg_pending),
        .cfg_active(cfg_active), .ctrl_set(ctrl_set), .ctrl_cnt_rst(ctrl_cnt_rst),
        .ctrl_out_set(ctrl_out_set), .ctrl_out_rst(ctrl_out_rst), .host_kick(host_kick),
        .preset_val(preset_val), .pulse_len(pulse_len), .gate(gate), .cnt_in(cnt_in),
        .count(count), .dout(dout)
    );

    // Stimulus vectors: {cfg[40:25], gate[24], pulses[23:16], expected count[15:0]}
    localparam logic [40:0] VECS [0:4] = '{
        {16'h0074, 1'b1, 8'd3, 16'd3},   // R3 gate high counts (bit8=0)
        {16'h0074, 1'b0, 8'd4, 16'd0},   // R3 gate low blocks
        {16'h0174, 1'b1, 8'd2, 16'd0},   // R3 bit8=1, gate high blocks
        {16'h0174, 1'b0, 8'd5, 16'd5},   // R3 bit8=1, gate low counts
        {16'hFA77, 1'b1, 8'd3, 16'd3}    // R9 unused bits set, same as 0x0074
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [15:0] v);
        @(negedge clk);
        wr_unlock = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        wr_unlock = 1'b0; cfg_wr_en = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_in = 1'b1; repeat (4) @(negedge clk);
            cnt_in = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    task automatic out_set();  ctrl_out_set = 1'b1; @(negedge clk); ctrl_out_set = 1'b0; @(negedge clk); endtask
    task automatic out_rst();  ctrl_out_rst = 1'b1; @(negedge clk); ctrl_out_rst = 1'b0; @(negedge clk); endtask
    task automatic cnt_rst();  ctrl_cnt_rst = 1'b1; @(negedge clk); ctrl_cnt_rst = 1'b0; @(negedge clk); endtask
    task automatic kick();     host_kick = 1'b1; @(negedge clk); host_kick = 1'b0; endtask

    initial begin
        repeat (3) @(negedge clk);
        factory_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 count after reset", 32'(count), 0);
        check("R10 dout after reset", 32'(dout), 0);
        check("R2 default pending", 32'(cfg_pending), 32'h0108);
        check("R2 default active", 32'(cfg_active), 32'h0108);

        // R1: locked write ignored
        cfg_wr_en = 1'b1; cfg_wr_data = 16'h0014;
        @(negedge clk); cfg_wr_en = 1'b0; @(negedge clk);
        check("R1 locked write", 32'(cfg_pending), 32'h0108);

        // R2: unlocked write is pending only until power-on reset
        wr_unlock = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = 16'h0014;
        @(negedge clk); wr_unlock = 1'b0; cfg_wr_en = 1'b0; @(negedge clk);
        check("R1 unlocked write", 32'(cfg_pending), 32'h0014);
        check("R2 active unchanged", 32'(cfg_active), 32'h0108);
        out_set();
        check("R2 old config still rules", 32'(dout), 0);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R2 active after reset", 32'(cfg_active), 32'h0014);
        out_set();
        check("R2 new config in force", 32'(dout), 1);

        // Vector table: gate polarity and unused bits
        for (int k = 0; k < 5; k++) begin
            apply_cfg(VECS[k][40:25]);
            gate = VECS[k][24];
            @(negedge clk);
            pulses(int'(VECS[k][23:16]));
            check($sformatf("R3/R9 vector %0d count", k), 32'(count), 32'(VECS[k][15:0]));
            check($sformatf("R9 vector %0d readback", k), 32'(cfg_active), 32'(VECS[k][40:25]));
        end

        // R4: level preset
        gate = 1'b1;
        apply_cfg(16'h0074);
        preset_val = 16'd100; ctrl_set = 1'b1;
        pulses(1);
        check("R4 level holds preset", 32'(count), 100);
        ctrl_set = 1'b0; @(negedge clk);
        pulses(1);
        check("R4 level released counts", 32'(count), 101);

        // R4: edge preset
        apply_cfg(16'h007C);
        preset_val = 16'd50; ctrl_set = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 edge loads", 32'(count), 50);
        pulses(1);
        check("R4 edge counts while held", 32'(count), 51);
        ctrl_set = 1'b0; @(negedge clk);

        // R5: disabled commands
        apply_cfg(16'h0004);
        out_set();
        check("R5 set disabled", 32'(dout), 0);
        pulses(2);
        cnt_rst();
        check("R5 counter reset disabled", 32'(count), 2);
        apply_cfg(16'h0014);
        out_set();
        check("R5 set enabled", 32'(dout), 1);
        out_rst();
        check("R5 output reset disabled", 32'(dout), 1);

        // R6: counter reset clears output
        apply_cfg(16'h0074);
        out_set();
        pulses(2);
        check("R6 count before reset", 32'(count), 2);
        cnt_rst();
        check("R6 count cleared", 32'(count), 0);
        check("R6 dout cleared", 32'(dout), 0);

        // R7: pulse length
        apply_cfg(16'h04F4);
        pulse_len = 16'd5;
        ctrl_out_set = 1'b1; @(negedge clk); ctrl_out_set = 1'b0;
        check("R7 pulse starts", 32'(dout), 1);
        repeat (4) @(negedge clk);
        check("R7 pulse last cycle", 32'(dout), 1);
        @(negedge clk);
        check("R7 pulse ended", 32'(dout), 0);
        pulse_len = 16'd200;
        out_set();
        cnt_rst();
        check("R7 counter reset keeps pulse", 32'(dout), 1);
        out_rst();
        check("R5 output reset enabled", 32'(dout), 0);

        // R8: watchdog
        apply_cfg(16'h0070);
        out_set();
        for (int j = 0; j < 5; j++) begin
            repeat (20) @(negedge clk);
            kick();
        end
        check("R8 kicked output holds", 32'(dout), 1);
        repeat (60) @(negedge clk);
        check("R8 watchdog clears", 32'(dout), 0);
        apply_cfg(16'h0074);
        out_set();
        repeat (100) @(negedge clk);
        check("R8 watchdog disabled", 32'(dout), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule